// File: doc/BRIEF.md
# Sector-Granular Bidirectional Transfer Buffer Controller

This block is the control core of a circular staging buffer placed between a host-side DMA channel and a disk-side DMA channel. It holds two free-running word counters, one for filling and one for draining. It hands the external buffer RAM a write address and a read address, each the counter taken modulo the capacity. It also grants at most one 16-bit word move per side per clock. The buffer holds SECTORS sectors of SECT_BYTES bytes, 8192 bytes by default. The data path and the RAM itself sit outside the block.

A single host direction bit decides the roles. When the host writes, the host fills the buffer and the disk drains it, but only while the disk is set to its write direction. When the host reads, the disk fills the buffer while it is set to read, and the host drains it. Both sides may move in the same cycle, so the buffer refills while the host drains it. A status field gives the occupancy in whole sectors while the host reads, and the free space in whole sectors while the host writes. Three level interrupt causes report empty, holding data and full.

A host transfer request carries a byte length. It is tracked by a three-state machine. HQ_IDLE goes to HQ_BUSY on a start whose rounded word count is non-zero. HQ_IDLE goes to HQ_DONE on a start of zero length. HQ_BUSY goes to HQ_DONE on the move of the last word. HQ_DONE always returns to HQ_IDLE after one cycle, and the completion pulse is high during that cycle.

Top module: `sbuf_top`

## Requirements
- R1: fill_addr equals the number of words filled since reset modulo the capacity in words, drain_addr likewise for words drained; both wrap from the last word to 0.
- R2: With host_dir_wr=1 the host is the filler and the disk drains only when disk_dma_en, disk_ready are high and disk_dir_rd=0; with host_dir_wr=0 the disk fills only when disk_dma_en, disk_ready and disk_dir_rd=1 are all high, and the host is the drainer. host_move and disk_move mark which side moves.
- R3: A fill is granted only while occupancy is below capacity, a drain only while occupancy is above zero; a fill and a drain in the same cycle leave occupancy unchanged.
- R4: With count = occupancy words / words per sector, stat_sectors = count when host_dir_wr=0 and SECTORS − count when host_dir_wr=1; stat_none is 1 only when host_dir_wr=1 and count is 0.
- R5: irq_empty is 1 exactly when occupancy is zero, irq_data exactly when it is non-zero; never both.
- R6: irq_full is 1 exactly when occupancy equals the capacity.
- R7: A host_req_start in HQ_IDLE loads ceil(host_req_bytes/2) words; the host side moves only in HQ_BUSY with host_dma_en high, one word per move.
- R8: host_done is high for exactly one cycle, the cycle after the last host word move, or the cycle after a zero-length start.
- R9: host_req_start is ignored outside HQ_IDLE.
- R10: After reset the counters are zero, the state is HQ_IDLE, irq_empty is 1 and host_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_dir_wr | input | 1 | 1: host writes into buffer; 0: host reads |
| host_dma_en | input | 1 | Host DMA channel enabled |
| host_req_start | input | 1 | Start a host request (pulse) |
| host_req_bytes | input | LEN_W | Host request length in bytes |
| disk_dir_rd | input | 1 | 1: disk fills buffer; 0: disk drains |
| disk_dma_en | input | 1 | Disk DMA channel enabled |
| disk_ready | input | 1 | Disk side ready to move data |
| fill_en | output | 1 | Write one word into the RAM this cycle |
| fill_addr | output | AW | RAM word address for the fill |
| drain_en | output | 1 | Read one word from the RAM this cycle |
| drain_addr | output | AW | RAM word address for the drain |
| host_move | output | 1 | Host side moves a word this cycle |
| disk_move | output | 1 | Disk side moves a word this cycle |
| stat_sectors | output | SW | Sectors held or free, by direction |
| stat_none | output | 1 | Host-write mode with no whole sector held |
| irq_empty | output | 1 | Empty cause |
| irq_data | output | 1 | Has-data cause |
| irq_full | output | 1 | Full cause |
| host_done | output | 1 | Host request completion pulse |

## Verification
The bench builds the block with 8-byte sectors and 4 sectors, so the capacity is 16 words. Filling to full, draining to empty and wrapping both addresses then take only a few dozen cycles. With four words per sector, partial sectors occur often, so the status truncation and the stat_none flag in write mode are exercised. Request lengths above the capacity, odd lengths and zero lengths bring stalls at full and at empty, rounding and the immediate completion path within reach.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
    typedef enum logic [1:0] {
        HQ_IDLE = 2'd0,
        HQ_BUSY = 2'd1,
        HQ_DONE = 2'd2
    } hq_state_t;
endpackage

// File: rtl/sbuf_ptrs.sv
module sbuf_ptrs #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_en,
    input  logic          drain_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   occ
);
    logic [AW:0] wr_cnt;
    logic [AW:0] rd_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
            rd_cnt <= '0;
        end else begin
            if (fill_en)  wr_cnt <= wr_cnt + 1'b1;
            if (drain_en) rd_cnt <= rd_cnt + 1'b1;
        end
    end

    assign wr_addr = wr_cnt[AW-1:0];
    assign rd_addr = rd_cnt[AW-1:0];
    assign occ     = wr_cnt - rd_cnt;
endmodule

// File: rtl/sbuf_arbiter.sv
module sbuf_arbiter #(
    parameter int AW = 12
) (
    input  logic        host_dir_wr,
    input  logic        host_active,
    input  logic        disk_dir_rd,
    input  logic        disk_go,
    input  logic [AW:0] occ,
    output logic        fill_en,
    output logic        drain_en,
    output logic        host_move,
    output logic        disk_move
);
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    logic can_fill;
    logic can_drain;

    assign can_fill  = (occ != CAP);
    assign can_drain = (occ != '0);

    always_comb begin
        if (host_dir_wr) begin
            fill_en   = host_active & can_fill;
            drain_en  = disk_go & ~disk_dir_rd & can_drain;
            host_move = fill_en;
            disk_move = drain_en;
        end else begin
            fill_en   = disk_go & disk_dir_rd & can_fill;
            drain_en  = host_active & can_drain;
            host_move = drain_en;
            disk_move = fill_en;
        end
    end
endmodule

// File: rtl/sbuf_hostreq.sv
module sbuf_hostreq
    import sbuf_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] bytes,
    input  logic             dma_en,
    input  logic             host_move,
    output logic             host_active,
    output logic             host_done
);
    hq_state_t        state_q, state_d;
    logic [LEN_W-1:0] remain_q, remain_d;
    logic [LEN_W-1:0] req_words;

    assign req_words = (bytes >> 1) + {{(LEN_W-1){1'b0}}, bytes[0]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= HQ_IDLE;
            remain_q <= '0;
        end else begin
            state_q  <= state_d;
            remain_q <= remain_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        remain_d = remain_q;
        unique case (state_q)
            HQ_IDLE: begin
                if (start) begin
                    remain_d = req_words;
                    state_d  = (req_words == '0) ? HQ_DONE : HQ_BUSY;
                end
            end
            HQ_BUSY: begin
                if (host_move) begin
                    remain_d = remain_q - 1'b1;
                    if (remain_q == {{(LEN_W-1){1'b0}}, 1'b1})
                        state_d = HQ_DONE;
                end
            end
            HQ_DONE: begin
                state_d = HQ_IDLE;
            end
            default: begin
                state_d = HQ_IDLE;
            end
        endcase
    end

    always_comb begin
        host_active = 1'b0;
        host_done   = 1'b0;
        unique case (state_q)
            HQ_IDLE: ;
            HQ_BUSY: host_active = dma_en;
            HQ_DONE: host_done   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/sbuf_status.sv
module sbuf_status #(
    parameter int AW      = 12,
    parameter int SECT_SH = 8,
    parameter int SECTORS = 16
) (
    input  logic              host_dir_wr,
    input  logic [AW:0]       occ,
    output logic [AW-SECT_SH:0] stat_sectors,
    output logic              stat_none,
    output logic              irq_empty,
    output logic              irq_data,
    output logic              irq_full
);
    localparam int          SW  = AW + 1 - SECT_SH;
    localparam logic [AW:0] CAP = (AW+1)'(1) << AW;

    logic [SW-1:0] count;

    assign count = occ[AW:SECT_SH];

    always_comb begin
        if (host_dir_wr) begin
            stat_sectors = SW'(SECTORS) - count;
            stat_none    = (count == '0);
        end else begin
            stat_sectors = count;
            stat_none    = 1'b0;
        end
    end

    assign irq_empty = (occ == '0);
    assign irq_data  = (occ != '0);
    assign irq_full  = (occ == CAP);
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top #(
    parameter int SECT_BYTES = 512,
    parameter int SECTORS    = 16,
    parameter int LEN_W      = 16,
    localparam int SECT_WORDS = SECT_BYTES / 2,
    localparam int CAP_WORDS  = SECT_WORDS * SECTORS,
    localparam int AW         = $clog2(CAP_WORDS),
    localparam int SECT_SH    = $clog2(SECT_WORDS),
    localparam int SW         = AW + 1 - SECT_SH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_dir_wr,
    input  logic             host_dma_en,
    input  logic             host_req_start,
    input  logic [LEN_W-1:0] host_req_bytes,
    input  logic             disk_dir_rd,
    input  logic             disk_dma_en,
    input  logic             disk_ready,
    output logic             fill_en,
    output logic [AW-1:0]    fill_addr,
    output logic             drain_en,
    output logic [AW-1:0]    drain_addr,
    output logic             host_move,
    output logic             disk_move,
    output logic [SW-1:0]    stat_sectors,
    output logic             stat_none,
    output logic             irq_empty,
    output logic             irq_data,
    output logic             irq_full,
    output logic             host_done
);
    logic [AW:0] occ;
    logic        host_active;
    logic        disk_go;

    assign disk_go = disk_dma_en & disk_ready;

    sbuf_ptrs #(.AW(AW)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .fill_en  (fill_en),
        .drain_en (drain_en),
        .wr_addr  (fill_addr),
        .rd_addr  (drain_addr),
        .occ      (occ)
    );

    sbuf_arbiter #(.AW(AW)) u_arb (
        .host_dir_wr (host_dir_wr),
        .host_active (host_active),
        .disk_dir_rd (disk_dir_rd),
        .disk_go     (disk_go),
        .occ         (occ),
        .fill_en     (fill_en),
        .drain_en    (drain_en),
        .host_move   (host_move),
        .disk_move   (disk_move)
    );

    sbuf_hostreq #(.LEN_W(LEN_W)) u_hreq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (host_req_start),
        .bytes       (host_req_bytes),
        .dma_en      (host_dma_en),
        .host_move   (host_move),
        .host_active (host_active),
        .host_done   (host_done)
    );

    sbuf_status #(.AW(AW), .SECT_SH(SECT_SH), .SECTORS(SECTORS)) u_stat (
        .host_dir_wr  (host_dir_wr),
        .occ          (occ),
        .stat_sectors (stat_sectors),
        .stat_none    (stat_none),
        .irq_empty    (irq_empty),
        .irq_data     (irq_data),
        .irq_full     (irq_full)
    );
endmodule

// File: rtl/sbuf_checker.sv
module sbuf_checker #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fill_en,
    input logic          drain_en,
    input logic [AW-1:0] fill_addr,
    input logic [AW-1:0] drain_addr,
    input logic          irq_empty,
    input logic          irq_data,
    input logic          irq_full,
    input logic          host_done
);
    // R1
    fill_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> fill_addr == $past(fill_addr) + AW'(1));

    // R1
    drain_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_en |=> drain_addr == $past(drain_addr) + AW'(1));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full |-> !fill_en);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_empty |-> !drain_en);

    // R5
    cause_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({irq_empty, irq_data}) == 1);

    // R6
    full_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_full |-> irq_data);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done);
endmodule

bind sbuf_top sbuf_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .drain_en   (drain_en),
    .fill_addr  (fill_addr),
    .drain_addr (drain_addr),
    .irq_empty  (irq_empty),
    .irq_data   (irq_data),
    .irq_full   (irq_full),
    .host_done  (host_done)
);

// File: tb/sbuf_top_test.sv
module sbuf_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int SB    = 8;
    localparam int NS    = 4;
    localparam int SPW   = SB / 2;
    localparam int CAP   = SPW * NS;
    localparam int AW    = $clog2(CAP);
    localparam int SW    = AW + 1 - $clog2(SPW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_dir_wr = 1'b0, host_dma_en = 1'b0, host_req_start = 1'b0;
    logic [15:0] host_req_bytes = '0;
    logic disk_dir_rd = 1'b0, disk_dma_en = 1'b0, disk_ready = 1'b0;
    logic fill_en, drain_en, host_move, disk_move, stat_none;
    logic irq_empty, irq_data, irq_full, host_done;
    logic [AW-1:0] fill_addr, drain_addr;
    logic [SW-1:0] stat_sectors;

    int checks = 0;
    int errors = 0;
    int m_occ = 0, m_wr = 0, m_rd = 0, m_st = 0, m_rem = 0, m_dones = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbuf_top #(.SECT_BYTES(SB), .SECTORS(NS), .LEN_W(16)) uut (
        .clk(clk), .rst_n(rst_n), .host_dir_wr(host_dir_wr), .host_dma_en(host_dma_en),
        .host_req_start(host_req_start), .host_req_bytes(host_req_bytes),
        .disk_dir_rd(disk_dir_rd), .disk_dma_en(disk_dma_en), .disk_ready(disk_ready),
        .fill_en(fill_en), .fill_addr(fill_addr), .drain_en(drain_en), .drain_addr(drain_addr),
        .host_move(host_move), .disk_move(disk_move), .stat_sectors(stat_sectors),
        .stat_none(stat_none), .irq_empty(irq_empty), .irq_data(irq_data),
        .irq_full(irq_full), .host_done(host_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: evaluated at each falling edge, advanced for the next rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit hact, dgo, ef, ed, eh, ek;
            int cnt;
            hact = (m_st == 1) && host_dma_en;
            dgo  = disk_dma_en && disk_ready;
            if (host_dir_wr) begin
                ef = hact && (m_occ < CAP);
                ed = dgo && !disk_dir_rd && (m_occ > 0);
                eh = ef; ek = ed;
            end else begin
                ef = dgo && disk_dir_rd && (m_occ < CAP);
                ed = hact && (m_occ > 0);
                eh = ed; ek = ef;
            end
            chk("R2/R3 fill_en", fill_en, ef);
            chk("R2/R3 drain_en", drain_en, ed);
            chk("R2 host_move", host_move, eh);
            chk("R2 disk_move", disk_move, ek);
            chk("R1 fill_addr", fill_addr, m_wr);
            chk("R1 drain_addr", drain_addr, m_rd);
            cnt = m_occ / SPW;
            chk("R4 stat_sectors", stat_sectors, host_dir_wr ? NS - cnt : cnt);
            chk("R4 stat_none", stat_none, host_dir_wr && cnt == 0);
            chk("R5 irq_empty", irq_empty, m_occ == 0);
            chk("R5 irq_data", irq_data, m_occ != 0);
            chk("R6 irq_full", irq_full, m_occ == CAP);
            chk("R8 host_done", host_done, m_st == 2);
            if (host_done) m_dones++;
            m_wr  = (m_wr + int'(ef)) % CAP;
            m_rd  = (m_rd + int'(ed)) % CAP;
            m_occ = m_occ + int'(ef) - int'(ed);
            case (m_st)
                0: if (host_req_start) begin
                       m_rem = (host_req_bytes + 1) / 2;
                       m_st  = (m_rem == 0) ? 2 : 1;
                   end
                1: if (eh) begin
                       m_rem--;
                       if (m_rem == 0) m_st = 2;
                   end
                default: m_st = 0;
            endcase
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic request(input int nbytes);
        host_req_bytes = 16'(nbytes);
        host_req_start = 1'b1;
        step(1);
        host_req_start = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10: reset state
        chk("R10 irq_empty", irq_empty, 1);
        chk("R10 host_done", host_done, 0);
        chk("R10 fill_addr", fill_addr, 0);
        chk("R10 drain_addr", drain_addr, 0);
        step(1);

        // Host writes 40 bytes: stalls at full (R7, R3)
        host_dir_wr = 1'b1; host_dma_en = 1'b1;
        request(40);
        step(3);
        request(2);            // R9: ignored while busy
        step(20);
        chk("R6 full reached", irq_full, 1);
        chk("R4 no free sector", stat_sectors, 0);
        // Disk drains while host still fills
        disk_dma_en = 1'b1; disk_ready = 1'b1; disk_dir_rd = 1'b0;
        step(30);
        chk("R9 one completion", m_dones, 1);
        chk("R5 drained", irq_empty, 1);
        disk_dma_en = 1'b0;

        // Host-read mode: disk fills to full
        host_dir_wr = 1'b0; disk_dir_rd = 1'b1; disk_dma_en = 1'b1;
        step(20);
        chk("R6 full in read mode", irq_full, 1);
        // Read 10 bytes with DMA disabled for a while (R7)
        host_dma_en = 1'b0;
        request(10);
        step(5);
        chk("R7 stalled without enable", irq_full, 1);
        host_dma_en = 1'b1;
        step(8);
        // Odd length and zero length (R7, R8)
        request(7);
        step(6);
        request(0);
        step(3);
        chk("R8 completions so far", m_dones, 4);

        // Host reads more than present with disk paused (R3)
        disk_dma_en = 1'b0;
        request(60);
        step(25);
        chk("R5 empty while host waits", irq_empty, 1);
        disk_dma_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            disk_ready = (i % 3) != 0;
            step(1);
        end
        disk_ready = 1'b1;
        step(20);
        chk("R8 all requests complete", m_dones, 5);

        // Direction flip back to write with partial sector present (R4)
        disk_dma_en = 1'b0;
        host_dir_wr = 1'b1;
        step(2);
        request(6);
        step(6);
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule